// File: doc/BRIEF.md
# Stuck Two-Wire Bus Detector with Clock Recovery

This block watches both sides of a buffered two-wire (I2C) bus and decides when the bus is stuck low. The bus counts as healthy whenever, in the same clock cycle, clock and data are both high on the downstream side. While the two sides are joined, the upstream side must also be high in that cycle. If no such cycle occurs within a long window (45 ms by default), the block raises a fault flag.

A recovery-enable strap selects what happens next. With the strap low, the block only reports the fault. It clears the flag as soon as the bus is seen high again. With the strap high, the block asks the connection controller to split the two sides. After a settling gap it clocks the downstream side with a burst of slow pulses to free a slave that is holding data low. It then issues a stop condition. The burst ends early if the downstream bus floats high. Once the fault clears, the block drops its split request. Rejoining the two sides after a stop or idle is left to the connection controller.

All pins are plain level signals. The block carries no data stream, so it has no valid/ready handshake and no back-pressure. The bus inputs are expected to be synchronized already. The two pull outputs enable open-drain drivers that pull the downstream lines low.

Top module: `stuck_bus_recovery`

## Requirements
- R1: While reset is asserted, and right after it, the fault flag, the split request and both pull outputs are 0.
- R2: The fault flag rises on the STUCK_CYC-th consecutive clock edge at which the bus is not high. It stays 0 after STUCK_CYC-1 such edges.
- R3: "Bus high" needs downstream clock and data high together. While `linked` is 1, upstream clock and data must also be high. A single low line on either side, including upstream only, counts as not high.
- R4: One edge at which the bus is high restarts the window from zero.
- R5: With `recover_en` = 0 at the moment of detection, the block only raises the fault flag. The split request and both pulls stay 0. The flag drops at the first edge after the bus is seen high.
- R6: With `recover_en` = 1 at detection, the split request rises together with the fault flag. The first clock pull starts GAP_CYC cycles later.
- R7: The recovery burst has exactly MAX_PULSES clock pulses. Each pulse holds the clock pull at 1 for HALF_CYC cycles, then at 0 for HALF_CYC cycles (50 % duty).
- R8: After the burst a stop condition follows, each phase lasting HALF_CYC cycles: first both pulls are 1; then the clock is released while data is still pulled; then data is released while the clock is released.
- R9: If the downstream clock and data are both high while the split request is active and neither pull is active, then at the next edge the fault flag drops, the pulls stay 0 and the burst stops.
- R10: If the bus is still stuck after the stop, the fault flag and split request stay 1. A new STUCK_CYC window starts on the downstream side, and a new gap and burst follow when it expires.
- R11: The split request drops in the same cycle as the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_scl | input | 1 | Synchronized upstream clock level |
| in_sda | input | 1 | Synchronized upstream data level |
| out_scl | input | 1 | Synchronized downstream clock level |
| out_sda | input | 1 | Synchronized downstream data level |
| recover_en | input | 1 | Strap: 1 = split and clock the bus on a fault, 0 = flag only |
| linked | input | 1 | From the connection controller: 1 while the two sides are joined |
| stuck_fault | output | 1 | Stuck-bus fault flag |
| split_req | output | 1 | Request to the connection controller to keep the sides apart |
| out_scl_pull | output | 1 | Open-drain pull-low enable for the downstream clock |
| out_sda_pull | output | 1 | Open-drain pull-low enable for the downstream data |

## Verification
Every output comes from a register updated by the same clock, so a change in the bus lines shows up in the outputs one edge after the edge that samples it. The fault flag rises on exactly the STUCK_CYC-th edge of a stuck bus. The first clock pull comes GAP_CYC edges after that, and the pull level then toggles every HALF_CYC edges. The bench drives the lines on falling edges and counts rising edges from the change. It then reads the outputs on the next falling edge, checking one edge short of each deadline and one edge on it. Pulse and stop counts come from a falling-edge monitor that watches only the pull outputs.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;

  typedef enum logic [3:0] {
    ST_WATCH,
    ST_FLAG,
    ST_GAP,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_STP_LL,
    ST_STP_HL,
    ST_STP_HH,
    ST_REARM
  } rec_state_t;

  // cycles in a span of microseconds, never less than one
  function automatic int unsigned span_cycles(input longint unsigned clk_khz,
                                              input longint unsigned span_us);
    longint unsigned c;
    c = clk_khz * span_us / 64'd1000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

  // cycles in half a period of a pulse train
  function automatic int unsigned half_cycles(input longint unsigned clk_khz,
                                              input longint unsigned pulse_hz);
    longint unsigned c;
    c = clk_khz * 64'd1000 / (64'd2 * pulse_hz);
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/sbr_window_timer.sv
`timescale 1ns/1ps
module sbr_window_timer #(
  parameter int unsigned LIMIT = 100,
  parameter int unsigned W     = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic seen_high,
  output logic expire
);

  logic [W-1:0] cnt;

  assign expire = run && !seen_high && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || seen_high || expire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sbr_phase_timer.sv
`timescale 1ns/1ps
module sbr_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         done
);

  logic [W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/sbr_sequencer.sv
`timescale 1ns/1ps
module sbr_sequencer
  import sbr_pkg::*;
#(
  parameter int unsigned MAX_PULSES = 16,
  parameter int unsigned GAP_CYC    = 8,
  parameter int unsigned HALF_CYC   = 5,
  parameter int unsigned IW         = 4,
  parameter int unsigned PW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expire,
  input  logic          bus_high,
  input  logic          out_free,
  input  logic          recover_en,
  input  logic          phase_done,
  output logic          phase_load,
  output logic [IW-1:0] phase_len,
  output logic          window_run,
  output logic          window_high,
  output logic          fault,
  output logic          split,
  output logic          scl_pull,
  output logic          sda_pull
);

  rec_state_t    state, nxt;
  logic [PW-1:0] pcnt;
  logic          last_pulse;

  assign last_pulse = (pcnt == PW'(MAX_PULSES - 1));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_WATCH:  if (expire) nxt = recover_en ? ST_GAP : ST_FLAG;
      ST_FLAG:   if (bus_high) nxt = ST_WATCH;
      ST_GAP: begin
        if (out_free)        nxt = ST_WATCH;
        else if (phase_done) nxt = ST_CLK_LO;
      end
      ST_CLK_LO: begin
        if (out_free)        nxt = ST_WATCH;
        else if (phase_done) nxt = ST_CLK_HI;
      end
      ST_CLK_HI: begin
        if (out_free)        nxt = ST_WATCH;
        else if (phase_done) nxt = last_pulse ? ST_STP_LL : ST_CLK_LO;
      end
      ST_STP_LL: if (phase_done) nxt = ST_STP_HL;
      ST_STP_HL: if (phase_done) nxt = ST_STP_HH;
      ST_STP_HH: begin
        if (out_free)        nxt = ST_WATCH;
        else if (phase_done) nxt = ST_REARM;
      end
      ST_REARM: begin
        if (out_free)    nxt = ST_WATCH;
        else if (expire) nxt = ST_GAP;
      end
      default: nxt = ST_WATCH;
    endcase
  end

  assign phase_load  = (nxt != state);
  assign phase_len   = (nxt == ST_GAP) ? IW'(GAP_CYC) : IW'(HALF_CYC);
  assign window_run  = (state == ST_WATCH) || (state == ST_REARM);
  // once split, only the downstream side matters for release
  assign window_high = (state == ST_REARM) ? out_free : bus_high;

  assign split    = (state != ST_WATCH) && (state != ST_FLAG);
  assign scl_pull = (state == ST_CLK_LO) || (state == ST_STP_LL);
  assign sda_pull = (state == ST_STP_LL) || (state == ST_STP_HL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WATCH;
      fault <= 1'b0;
      pcnt  <= '0;
    end else begin
      state <= nxt;
      fault <= (nxt != ST_WATCH);
      if (nxt == ST_GAP && state != ST_GAP) begin
        pcnt <= '0;
      end else if (state == ST_CLK_HI && nxt == ST_CLK_LO) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/stuck_bus_recovery.sv
`timescale 1ns/1ps
module stuck_bus_recovery
  import sbr_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 125000,
  parameter int unsigned STUCK_US   = 45000,
  parameter int unsigned GAP_US     = 40,
  parameter int unsigned PULSE_HZ   = 5500,
  parameter int unsigned MAX_PULSES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_scl,
  input  logic in_sda,
  input  logic out_scl,
  input  logic out_sda,
  input  logic recover_en,
  input  logic linked,
  output logic stuck_fault,
  output logic split_req,
  output logic out_scl_pull,
  output logic out_sda_pull
);

  localparam int unsigned STUCK_CYC = span_cycles(CLK_KHZ, STUCK_US);
  localparam int unsigned GAP_CYC   = span_cycles(CLK_KHZ, GAP_US);
  localparam int unsigned HALF_CYC  = half_cycles(CLK_KHZ, PULSE_HZ);
  localparam int unsigned PHASE_MAX = (GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC;
  localparam int unsigned TW        = $clog2(STUCK_CYC + 1);
  localparam int unsigned IW        = $clog2(PHASE_MAX + 1);
  localparam int unsigned PW        = $clog2(MAX_PULSES + 1);

  logic bus_high, out_free;
  logic expire, window_run, window_high;
  logic phase_load, phase_done;
  logic [IW-1:0] phase_len;

  assign out_free = out_scl && out_sda;
  assign bus_high = out_free && (!linked || (in_scl && in_sda));

  sbr_window_timer #(
    .LIMIT (STUCK_CYC),
    .W     (TW)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (window_run),
    .seen_high (window_high),
    .expire    (expire)
  );

  sbr_phase_timer #(
    .W (IW)
  ) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (phase_load),
    .len   (phase_len),
    .done  (phase_done)
  );

  sbr_sequencer #(
    .MAX_PULSES (MAX_PULSES),
    .GAP_CYC    (GAP_CYC),
    .HALF_CYC   (HALF_CYC),
    .IW         (IW),
    .PW         (PW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire      (expire),
    .bus_high    (bus_high),
    .out_free    (out_free),
    .recover_en  (recover_en),
    .phase_done  (phase_done),
    .phase_load  (phase_load),
    .phase_len   (phase_len),
    .window_run  (window_run),
    .window_high (window_high),
    .fault       (stuck_fault),
    .split       (split_req),
    .scl_pull    (out_scl_pull),
    .sda_pull    (out_sda_pull)
  );

endmodule

// File: rtl/stuck_bus_recovery_chk.sv
`timescale 1ns/1ps
module stuck_bus_recovery_chk #(
  parameter int unsigned HALF_CYC = 5
) (
  input logic clk,
  input logic rst_n,
  input logic in_scl,
  input logic in_sda,
  input logic out_scl,
  input logic out_sda,
  input logic recover_en,
  input logic linked,
  input logic stuck_fault,
  input logic split_req,
  input logic out_scl_pull,
  input logic out_sda_pull
);

  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_run <= 0;
    else if (out_scl_pull) low_run <= low_run + 1;
    else                   low_run <= 0;
  end

  // R1
  quiet_in_reset_chk: assert property (@(posedge clk)
    !rst_n |-> !stuck_fault && !split_req && !out_scl_pull && !out_sda_pull);

  // R2
  fault_needs_low_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck_fault) |->
      $past(!(out_scl && out_sda && (!linked || (in_scl && in_sda)))));

  // R6
  split_follows_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck_fault) |-> split_req == $past(recover_en));

  // R7
  clock_low_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_scl_pull |-> low_run < HALF_CYC);

  // R8
  data_pull_under_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_sda_pull) |-> out_scl_pull);

  // R8
  stop_edge_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_sda_pull) |-> !out_scl_pull && $past(!out_scl_pull));

  // R9
  release_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_req && !out_scl_pull && !out_sda_pull && out_scl && out_sda
      |=> !stuck_fault && !split_req && !out_scl_pull);

endmodule

bind stuck_bus_recovery stuck_bus_recovery_chk #(
  .HALF_CYC (HALF_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_scl       (in_scl),
  .in_sda       (in_sda),
  .out_scl      (out_scl),
  .out_sda      (out_sda),
  .recover_en   (recover_en),
  .linked       (linked),
  .stuck_fault  (stuck_fault),
  .split_req    (split_req),
  .out_scl_pull (out_scl_pull),
  .out_sda_pull (out_sda_pull)
);

// File: tb/sim_stuck_bus_recovery.sv
`timescale 1ns/1ps
module sim_stuck_bus_recovery;

  // 1 MHz notional clock: window 100, gap 8, half period 5
  localparam int unsigned STUCK = 100;
  localparam int unsigned GAP   = 8;
  localparam int unsigned HALF  = 5;
  localparam int unsigned NPUL  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover_en = 1'b0;
  logic [3:0] stk = 4'b0000; // [3] in_scl, [2] in_sda, [1] out_scl, [0] out_sda held low
  logic in_scl, in_sda, out_scl, out_sda, linked;
  logic stuck_fault, split_req, out_scl_pull, out_sda_pull;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  int stops = 0;
  logic armed = 1'b0;
  logic p_scl = 1'b0;
  logic p_sda = 1'b0;

  always #4 clk = ~clk;

  assign in_scl  = ~stk[3];
  assign in_sda  = ~stk[2];
  assign out_scl = ~(out_scl_pull | stk[1]);
  assign out_sda = ~(out_sda_pull | stk[0]);
  assign linked  = ~split_req; // simple connection-controller model

  stuck_bus_recovery #(
    .CLK_KHZ    (1000),
    .STUCK_US   (STUCK),
    .GAP_US     (GAP),
    .PULSE_HZ   (100000),
    .MAX_PULSES (NPUL)
  ) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_scl       (in_scl),
    .in_sda       (in_sda),
    .out_scl      (out_scl),
    .out_sda      (out_sda),
    .recover_en   (recover_en),
    .linked       (linked),
    .stuck_fault  (stuck_fault),
    .split_req    (split_req),
    .out_scl_pull (out_scl_pull),
    .out_sda_pull (out_sda_pull)
  );

  // pulse and stop monitor, watching the pull outputs only
  always @(negedge clk) begin
    if (out_scl_pull && !p_scl && !out_sda_pull) pulses = pulses + 1;
    if (p_scl && !out_scl_pull && out_sda_pull && p_sda) armed = 1'b1;
    if (p_sda && !out_sda_pull && !out_scl_pull && armed) begin
      stops = stops + 1;
      armed = 1'b0;
    end
    p_scl = out_scl_pull;
    p_sda = out_sda_pull;
  end

  typedef struct packed {
    logic        disc;
    logic [3:0]  held;
    logic [15:0] hold;
    logic        exp_fault;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'b0001, 16'd99,  1'b0},  // R2 one short
    '{1'b0, 4'b0001, 16'd100, 1'b1},  // R2 on time
    '{1'b0, 4'b0010, 16'd100, 1'b1},  // R3 clock only
    '{1'b0, 4'b0100, 16'd100, 1'b1},  // R3 upstream data only
    '{1'b0, 4'b1001, 16'd100, 1'b1},  // R3 mixed sides
    '{1'b0, 4'b0000, 16'd150, 1'b0},  // R3 idle bus
    '{1'b1, 4'b0001, 16'd100, 1'b1},  // R6 then release in gap (R9)
    '{1'b1, 4'b0100, 16'd100, 1'b1},  // R3 with split enabled
    '{1'b1, 4'b0010, 16'd99,  1'b0}   // R2 one short with split enabled
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int base_p, base_s;
    @(negedge clk);
    // R1 reset state
    check(stuck_fault, 0, "R1", "fault in reset");
    check(split_req, 0, "R1", "split in reset");
    check(out_scl_pull | out_sda_pull, 0, "R1", "pulls in reset");
    step(2);
    rst_n = 1'b1;
    step(3);
    check(stuck_fault, 0, "R1", "fault after reset");

    // vector table
    for (int i = 0; i < NV; i++) begin
      recover_en = VEC[i].disc;
      stk = VEC[i].held;
      step(int'(VEC[i].hold));
      check(stuck_fault, VEC[i].exp_fault, "R2", $sformatf("vector %0d fault", i));
      check(split_req, VEC[i].exp_fault & VEC[i].disc, "R6", $sformatf("vector %0d split", i));
      stk = 4'b0000;
      step(4);
      check(stuck_fault, 0, "R9", $sformatf("vector %0d fault after release", i));
      check(split_req, 0, "R11", $sformatf("vector %0d split after release", i));
    end

    // R4 window restart
    recover_en = 1'b0;
    stk = 4'b0001;
    step(60);
    stk = 4'b0000;
    step(1);
    stk = 4'b0001;
    step(STUCK - 1);
    check(stuck_fault, 0, "R4", "fault after restart, one short");
    step(1);
    check(stuck_fault, 1, "R4", "fault after restart, on time");
    stk = 4'b0000;
    step(4);

    // R5 flag only
    base_p = pulses;
    stk = 4'b0010;
    step(300);
    check(stuck_fault, 1, "R5", "fault held");
    check(split_req, 0, "R5", "no split");
    check(pulses - base_p, 0, "R5", "no pulses");
    stk = 4'b0000;
    step(1);
    check(stuck_fault, 0, "R5", "clear one edge after high");

    // full burst, bus stays stuck: R6 R7 R8 R10
    recover_en = 1'b1;
    base_p = pulses;
    base_s = stops;
    stk = 4'b0001;
    step(STUCK);
    check(split_req, 1, "R6", "split with fault");
    step(GAP - 1);
    check(out_scl_pull, 0, "R6", "no pull before gap end");
    step(1);
    check(out_scl_pull, 1, "R6", "first pull after gap");
    step(HALF - 1);
    check(out_scl_pull, 1, "R7", "low half last cycle");
    step(1);
    check(out_scl_pull, 0, "R7", "high half start");
    step(HALF);
    check(out_scl_pull, 1, "R7", "second pulse start");
    step(300 - (STUCK + GAP + 2 * HALF));
    check(pulses - base_p, NPUL, "R7", "pulse count");
    check(stops - base_s, 1, "R8", "stop sequence");
    check(stuck_fault, 1, "R10", "fault kept after stop");
    check(split_req, 1, "R10", "split kept after stop");
    check(out_scl_pull | out_sda_pull, 0, "R10", "pulls idle in new window");
    step(90);
    check(out_scl_pull, 0, "R10", "no retry before window");
    step(1);
    check(out_scl_pull, 1, "R10", "retry burst starts");
    stk = 4'b0000;
    step(10);
    check(stuck_fault, 0, "R9", "fault after release in retry");
    check(split_req, 0, "R11", "split after release in retry");

    // early abort mid burst: R9 R11
    base_p = pulses;
    stk = 4'b0001;
    step(STUCK + 30);
    stk = 4'b0000;
    step(3);
    check(stuck_fault, 1, "R9", "fault while clock pulled");
    step(1);
    check(stuck_fault, 0, "R9", "fault cleared on release");
    check(split_req, 0, "R11", "split dropped with fault");
    check(out_scl_pull, 0, "R9", "clock released");
    step(20);
    check(pulses - base_p, 3, "R9", "burst cut short");

    // R1 reset during a fault
    stk = 4'b0001;
    step(STUCK + 2);
    rst_n = 1'b0;
    #1;
    check(stuck_fault, 0, "R1", "fault cleared by reset");
    check(split_req, 0, "R1", "split cleared by reset");
    stk = 4'b0000;
    step(2);
    rst_n = 1'b1;
    step(2);
    check(stuck_fault, 0, "R1", "fault after second reset");

    report();
  end

endmodule